// File: doc/BRIEF.md
# Protected System Clock Control Register

This block holds one byte of system clock configuration behind a bus write port. A write lands only when the bus address matches the register address and the protect-enable input is high. Separate lock inputs freeze the stop-request and clock-source bits. A stop request is refused while the PLL source bit is set or while oscillation-stop detection is enabled, and each refusal raises a one-cycle illegal flag.

The register drives the stop-mode request, the PLL source select (masked by two external disable inputs) and the oscillator drive-strength control. Hardware forces drive strength high when stop mode is entered outside low-speed mode, and when the main clock is switched off while in low-speed mode. A two-bit field selects a prescaler ratio for the main clock. The prescaler emits a single-cycle enable pulse once per ratio period. It picks up a new ratio only at its terminal count, so no shortened or stretched period is produced.

Top module: `sysclk_ctl`

## Requirements
- R1: After reset the register reads 8'h20 (drive-strength bit 5 high, all other bits low), and div_en_o pulses on every cycle.
- R2: A write updates the register only when wr_en_i is 1, wr_addr_i equals REG_ADDR and prot_en_i is 1. Any other write leaves every readable bit unchanged.
- R3: While mod_lock_i is 1, an accepted write leaves bit 0 (stop request) and bit 1 (PLL select) unchanged. Bits 5 and 7:6 still update.
- R4: While wdt_lock_i is 1, an accepted write leaves bit 0 unchanged.
- R5: Bits 4:2 always read zero, whatever value is written to them.
- R6: An accepted, unlocked write with data bit 0 set, made while register bit 1 is 1 or osc_det_en_i is 1, leaves bit 0 unchanged. illegal_o is then 1 for exactly the following cycle.
- R7: pll_sel_o is register bit 1 ANDed with the inverse of both pll_dis_a_i and pll_dis_b_i.
- R8: When bit 0 goes from 0 to 1 while low_speed_i is 0, bit 5 becomes 1 on that same edge, overriding the written value.
- R9: When main_off_i rises while low_speed_i is 1, bit 5 becomes 1 on that edge, overriding the written value.
- R10: Bits 7:6 select the prescaler ratio: 00 selects 1, 01 selects 2, 10 selects 4, 11 selects 16. div_en_o is high for one cycle per ratio period.
- R11: While div_gate_i is 1, the requested ratio is 1, whatever bits 7:6 hold.
- R12: A new ratio is taken only on the cycle in which div_en_o is high. The next period then uses the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | ADDR_W | Bus write address |
| wr_data_i | input | 8 | Bus write data |
| prot_en_i | input | 1 | Write protect key, 1 allows writes |
| mod_lock_i | input | 1 | Freezes bits 1:0 |
| wdt_lock_i | input | 1 | Freezes bit 0 |
| osc_det_en_i | input | 1 | Oscillation-stop detection enabled |
| low_speed_i | input | 1 | System is in low-speed mode |
| main_off_i | input | 1 | Main clock is switched off |
| div_gate_i | input | 1 | 1 forces a prescaler ratio of 1 |
| pll_dis_a_i | input | 1 | PLL select disable, first source |
| pll_dis_b_i | input | 1 | PLL select disable, second source |
| rd_data_o | output | 8 | Current register value |
| stop_req_o | output | 1 | Stop-mode request |
| pll_sel_o | output | 1 | Effective PLL clock select |
| drive_hi_o | output | 1 | Oscillator drive strength high |
| illegal_o | output | 1 | Refused stop request, one-cycle flag |
| div_en_o | output | 1 | Prescaled main clock enable pulse |

## Verification
A wrong gating decision in the write path shows on rd_data_o, stop_req_o or drive_hi_o. It is visible from the first clock edge after the faulty write, before any further bus activity can hide it. A wrong refusal or a missed refusal also shows on illegal_o exactly one cycle later. A wrong prescaler count or a ratio taken at the wrong moment moves the next div_en_o pulse. That error therefore appears within at most 16 cycles and keeps shifting every later pulse.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int unsigned REG_W = 8;
  localparam logic [REG_W-1:0] RST_VAL = 8'h20;
  localparam int unsigned B_STOP  = 0;
  localparam int unsigned B_PLL   = 1;
  localparam int unsigned B_DRIVE = 5;
  localparam int unsigned B_DIV_L = 6;
  localparam int unsigned MAX_RATIO = 16;
  localparam int unsigned TC_W = $clog2(MAX_RATIO);

  typedef enum logic [1:0] {DIV_1 = 2'b00, DIV_2 = 2'b01, DIV_4 = 2'b10, DIV_16 = 2'b11} div_sel_e;

  // terminal count = ratio - 1
  function automatic logic [TC_W-1:0] ratio_tc(input div_sel_e sel);
    case (sel)
      DIV_1:   ratio_tc = TC_W'(0);
      DIV_2:   ratio_tc = TC_W'(1);
      DIV_4:   ratio_tc = TC_W'(3);
      default: ratio_tc = TC_W'(MAX_RATIO - 1);
    endcase
  endfunction
endpackage

// File: rtl/sysclk_reg.sv
module sysclk_reg
  import sysclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ok_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             mod_lock_i,
  input  logic             wdt_lock_i,
  input  logic             osc_det_en_i,
  input  logic             low_speed_i,
  input  logic             main_off_i,
  output logic [REG_W-1:0] reg_o,
  output logic             illegal_o
);
  logic [REG_W-1:0] reg_q, reg_d;
  logic             ill_q, ill_d;
  logic             moff_q;
  logic             stop_try, stop_bad, stop_entry, moff_rise;

  always_comb begin
    reg_d      = reg_q;
    stop_try   = wr_ok_i && !mod_lock_i && !wdt_lock_i;
    stop_bad   = stop_try && wr_data_i[B_STOP] && (reg_q[B_PLL] || osc_det_en_i);
    ill_d      = stop_bad;
    if (stop_try && !stop_bad) reg_d[B_STOP] = wr_data_i[B_STOP];
    if (wr_ok_i && !mod_lock_i) reg_d[B_PLL] = wr_data_i[B_PLL];
    if (wr_ok_i) begin
      reg_d[B_DRIVE]           = wr_data_i[B_DRIVE];
      reg_d[B_DIV_L+1:B_DIV_L] = wr_data_i[B_DIV_L+1:B_DIV_L];
    end
    reg_d[4:2] = 3'b000;
    stop_entry = !reg_q[B_STOP] && reg_d[B_STOP] && !low_speed_i;
    moff_rise  = low_speed_i && main_off_i && !moff_q;
    if (stop_entry || moff_rise) reg_d[B_DRIVE] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q  <= RST_VAL;
      ill_q  <= 1'b0;
      moff_q <= 1'b0;
    end else begin
      reg_q  <= reg_d;
      ill_q  <= ill_d;
      moff_q <= main_off_i;
    end
  end

  assign reg_o     = reg_q;
  assign illegal_o = ill_q;

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) reg_q[4:2] == 3'b000); // R5
  AST_NO_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ok_i |=> $stable({reg_q[7:6], reg_q[1:0]})); // R2
  AST_MODLOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_lock_i |=> $stable(reg_q[1:0])); // R3
  AST_WDTLOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_lock_i |=> $stable(reg_q[B_STOP])); // R4
  AST_ILLEGAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ill_q |-> reg_q[B_STOP] == $past(reg_q[B_STOP])); // R6
  AST_STOP_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_q[B_STOP] && !low_speed_i) |=> (!reg_q[B_STOP] || reg_q[B_DRIVE])); // R8
endmodule

// File: rtl/sysclk_div.sv
module sysclk_div
  import sysclk_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      sel_i,
  input  logic            gate_i,
  output logic            pulse_o
);
  logic [TC_W-1:0] cnt_q, tc_q, tc_req;

  always_comb tc_req = gate_i ? TC_W'(0) : ratio_tc(div_sel_e'(sel_i));

  assign pulse_o = (cnt_q == tc_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tc_q  <= '0;
    end else if (pulse_o) begin
      cnt_q <= '0;
      tc_q  <= tc_req;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_q <= tc_q); // R10
  AST_RATIO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_o |=> $stable(tc_q)); // R12
  AST_GATE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && gate_i) |=> pulse_o); // R11
endmodule

// File: rtl/sysclk_ctl.sv
module sysclk_ctl
  import sysclk_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(8'h1C)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              prot_en_i,
  input  logic              mod_lock_i,
  input  logic              wdt_lock_i,
  input  logic              osc_det_en_i,
  input  logic              low_speed_i,
  input  logic              main_off_i,
  input  logic              div_gate_i,
  input  logic              pll_dis_a_i,
  input  logic              pll_dis_b_i,
  output logic [7:0]        rd_data_o,
  output logic              stop_req_o,
  output logic              pll_sel_o,
  output logic              drive_hi_o,
  output logic              illegal_o,
  output logic              div_en_o
);
  logic             wr_ok;
  logic [REG_W-1:0] reg_v;

  assign wr_ok = wr_en_i && (wr_addr_i == REG_ADDR) && prot_en_i;

  sysclk_reg u_reg (
    .clk_i, .rst_ni,
    .wr_ok_i(wr_ok), .wr_data_i,
    .mod_lock_i, .wdt_lock_i, .osc_det_en_i, .low_speed_i, .main_off_i,
    .reg_o(reg_v), .illegal_o
  );

  sysclk_div u_div (
    .clk_i, .rst_ni,
    .sel_i(reg_v[B_DIV_L+1:B_DIV_L]), .gate_i(div_gate_i),
    .pulse_o(div_en_o)
  );

  assign rd_data_o  = reg_v;
  assign stop_req_o = reg_v[B_STOP];
  assign drive_hi_o = reg_v[B_DRIVE];
  assign pll_sel_o  = reg_v[B_PLL] && !pll_dis_a_i && !pll_dis_b_i;

  AST_PLL_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_dis_a_i || pll_dis_b_i) |-> !pll_sel_o); // R7
  AST_PROT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prot_en_i |=> $stable(rd_data_o[1:0])); // R2
endmodule

// File: tb/tb_sysclk_ctl.sv
module tb_sysclk_ctl;
  localparam logic [7:0] ADDR = 8'h1C;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 0, prot_en_i = 0, mod_lock_i = 0, wdt_lock_i = 0, osc_det_en_i = 0;
  logic low_speed_i = 0, main_off_i = 0, div_gate_i = 0, pll_dis_a_i = 0, pll_dis_b_i = 0;
  logic [7:0] wr_addr_i = 0, wr_data_i = 0;
  logic [7:0] rd_data_o;
  logic stop_req_o, pll_sel_o, drive_hi_o, illegal_o, div_en_o;
  int total = 0, bad = 0;

  logic [7:0] m_reg;
  logic m_ill, m_moff;
  int m_cnt, m_tc;

  always #4 clk_i = ~clk_i;

  sysclk_ctl dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int tc_of(input logic [1:0] s, input logic g);
    if (g) return 0;
    case (s)
      2'b00: return 0;
      2'b01: return 1;
      2'b10: return 3;
      default: return 15;
    endcase
  endfunction

  task automatic compare_all();
    chk("R5 reserved", int'(rd_data_o[4:2]), 0);
    chk("R2 R3 R4 bits1:0", int'(rd_data_o[1:0]), int'(m_reg[1:0]));
    chk("R8 R9 drive bit", int'(rd_data_o[5]), int'(m_reg[5]));
    chk("R2 R10 div field", int'(rd_data_o[7:6]), int'(m_reg[7:6]));
    chk("R4 stop_req", int'(stop_req_o), int'(m_reg[0]));
    chk("R8 drive_hi", int'(drive_hi_o), int'(m_reg[5]));
    chk("R7 pll_sel", int'(pll_sel_o), int'(m_reg[1] && !pll_dis_a_i && !pll_dis_b_i));
    chk("R6 illegal", int'(illegal_o), int'(m_ill));
    chk("R10 R11 R12 div_en", int'(div_en_o), int'(m_cnt == m_tc));
  endtask

  // model update for the coming edge, using inputs now driven
  task automatic model_step();
    logic acc, unl, badst, entry, rise;
    logic [7:0] n;
    n     = m_reg;
    acc   = wr_en_i && wr_addr_i == ADDR && prot_en_i;
    unl   = acc && !mod_lock_i && !wdt_lock_i;
    badst = unl && wr_data_i[0] && (m_reg[1] || osc_det_en_i);
    if (unl && !badst) n[0] = wr_data_i[0];
    if (acc && !mod_lock_i) n[1] = wr_data_i[1];
    if (acc) begin n[5] = wr_data_i[5]; n[7:6] = wr_data_i[7:6]; end
    n[4:2] = 3'b000;
    entry = !m_reg[0] && n[0] && !low_speed_i;
    rise  = low_speed_i && main_off_i && !m_moff;
    if (entry || rise) n[5] = 1'b1;
    if (m_cnt == m_tc) begin m_cnt = 0; m_tc = tc_of(m_reg[7:6], div_gate_i); end
    else m_cnt++;
    m_reg  = n;
    m_ill  = badst;
    m_moff = main_off_i;
  endtask

  task automatic cycle();
    @(negedge clk_i);
    compare_all();
  endtask

  task automatic drive_write(input logic [7:0] d);
    wr_en_i = 1; wr_addr_i = ADDR; prot_en_i = 1; wr_data_i = d;
    model_step();
    cycle();
    wr_en_i = 0; prot_en_i = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin model_step(); cycle(); end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    m_reg = 8'h20; m_ill = 0; m_moff = 0; m_cnt = 0; m_tc = 0;
    #20;
    @(negedge clk_i);
    chk("R1 reset value", int'(rd_data_o), 32'h20);
    chk("R1 reset div_en", int'(div_en_o), 1);
    rst_ni = 1;
    idle(3);
    // R5: reserved bits written as ones
    drive_write(8'h1C);
    // R10: divide by 16 then divide by 2; R12 change waits for terminal count
    drive_write(8'hC0);
    idle(40);
    drive_write(8'h40);
    idle(20);
    // R11: gate forces ratio 1
    div_gate_i = 1; idle(20); div_gate_i = 0;
    // R6: PLL set then stop request refused
    drive_write(8'h02);
    drive_write(8'h03);
    idle(2);
    // R8: stop entry forces drive
    drive_write(8'h00);
    drive_write(8'h01);
    drive_write(8'h00);
    // R9: main clock off in low-speed mode
    low_speed_i = 1; idle(1); main_off_i = 1; idle(2); main_off_i = 0; low_speed_i = 0;
    // R3 R4: locks hold bits
    mod_lock_i = 1; drive_write(8'h03); mod_lock_i = 0;
    wdt_lock_i = 1; drive_write(8'h01); wdt_lock_i = 0;
    // random phase
    for (int i = 0; i < 3000; i++) begin
      wr_en_i      = ($urandom % 3) != 0;
      wr_addr_i    = (($urandom % 4) == 0) ? 8'($urandom) : ADDR;
      wr_data_i    = 8'($urandom);
      prot_en_i    = ($urandom % 4) != 0;
      mod_lock_i   = ($urandom % 5) == 0;
      wdt_lock_i   = ($urandom % 5) == 0;
      osc_det_en_i = ($urandom % 4) == 0;
      low_speed_i  = ($urandom % 2) == 0;
      main_off_i   = ($urandom % 3) == 0;
      div_gate_i   = ($urandom % 8) == 0;
      pll_dis_a_i  = ($urandom % 4) == 0;
      pll_dis_b_i  = ($urandom % 4) == 0;
      model_step();
      cycle();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule